// File: doc/BRIEF.md
# Cyclic Ring DMA Channel

This block is one DMA channel that streams 32-bit words round a ring buffer in memory, to or from a single peripheral stream. The ring is a contiguous run of equal periods. Software loads the period length, the number of periods, the ring base address, the direction and the burst size through a small register port, then writes the command register to start. In memory-to-peripheral mode the channel reads words through a single-word memory port and offers them on a transmit stream. In peripheral-to-memory mode it takes words from a receive stream and writes them to memory.

Each finished period sets a sticky interrupt flag, which drives a level interrupt, and advances a 16-bit count of completed periods. In ring mode the channel goes back to the base address after the last period and runs until software stops it. In any other mode it makes a single pass and then stops by itself. Stop and pause take effect only at a burst boundary, and the status register reports both.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset, every register reads 0, `irq` is low, and `memReq`, `txValid` and `rxReady` are low.
- R2: The registers are at these byte offsets: command 0x00, status 0x0C, interrupt status 0x10, interrupt clear 0x1C, control 0x24, config 0x28, source address 0x34, target address 0x3C, period length 0x44, period count 0x54. Control, config, source and target read back what was written. Interrupt clear always reads 0.
- R3: Writing 1 to command bit 0 starts the channel and sets status bit 0. The start is ignored and status bit 0 stays 0 if control bits 15:12 are neither 4 nor 2, or if the period length is 0.
- R4: With direction 4 (memory to peripheral), the channel reads words from the source address upward in steps of 4 bytes and presents them in order on `txData`. The ring holds config bits 30:28 plus one periods. In ring mode (control bits 9:8 equal to 2), the address returns to the source address after the last period.
- R5: With direction 2 (peripheral to memory), words taken from `rxData` are written in arrival order from the target address upward. The ring holds config bits 26:24 plus one periods.
- R6: If control bits 9:8 are not 2, the channel stops by itself after the last period of the ring, status bit 0 falls, and no memory beyond the ring is accessed.
- R7: If control bit 1 is 1, a word moves only on a `txValid`/`txReady` or `rxValid`/`rxReady` handshake. If control bit 1 is 0, `txReady` and `rxValid` are ignored and each stream beat lasts exactly one cycle.
- R8: Config bits 23:20 hold the burst length minus one. Writing 0 to command bit 0 makes status bit 0 fall at the next burst end or period end. The word in flight and the rest of its burst finish first.
- R9: Control bit 0 can be written while the channel runs. When it is 1, the channel halts at the next burst end or period end, and status bit 1 becomes 1. While paused there is no memory or stream traffic. Clearing the bit resumes with the next word of the sequence.
- R10: Each finished period sets interrupt status bit 0, and `irq` follows that bit. Writing 1 to bit 0 of the interrupt-clear register clears it.
- R11: Bits 15:0 of the period-count register count finished periods modulo 65536. The count returns to 0 on each start.
- R12: While status bit 0 is 1, writes to config, source, target and period length are ignored, and so are writes to control bits other than bit 0.
- R13: The period-length register keeps only bits 29:2 of the written value, so it reads back as the written value ANDed with 0x3FFFFFFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational on regAddr |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access completes this cycle |
| txValid | output | 1 | Transmit word valid |
| txData | output | 32 | Transmit word |
| txReady | input | 1 | Peripheral accepts transmit word |
| rxValid | input | 1 | Receive word valid |
| rxData | input | 32 | Receive word |
| rxReady | output | 1 | Channel accepts receive word |
| irq | output | 1 | Level interrupt, period done |

## Verification
The transmit direction runs as a three-period ring that is stopped partway. This shows whether the address wraps to the base and whether a stop lands on a period edge, because the number of words sent must equal twice the period count. The receive direction uses an irregular valid pattern and a single pass. This separates correct handshaking from skipped or duplicated words, and a sentinel just past the ring detects any overrun. A transmit run with the peripheral never ready and flow control off shows that ready is ignored. A paused run that also receives locked-register writes shows burst-granular halting, register freezing and seamless resumption. A one-word ring is left running long enough for the period count to roll over.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

  // register byte offsets
  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h0C;
  localparam logic [7:0] OFS_ISTAT = 8'h10;
  localparam logic [7:0] OFS_ICLR  = 8'h1C;
  localparam logic [7:0] OFS_CTRL  = 8'h24;
  localparam logic [7:0] OFS_CFG   = 8'h28;
  localparam logic [7:0] OFS_SRC   = 8'h34;
  localparam logic [7:0] OFS_TRG   = 8'h3C;
  localparam logic [7:0] OFS_LEN   = 8'h44;
  localparam logic [7:0] OFS_XSTAT = 8'h54;

  localparam logic [3:0]  DIR_TO_PERIPH = 4'd4;
  localparam logic [3:0]  DIR_TO_MEM    = 4'd2;
  localparam logic [1:0]  MODE_RING     = 2'd2;
  localparam logic [31:0] LEN_MASK      = 32'h3FFF_FFFC;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_PUSH, S_PULL, S_WR, S_HOLD
  } chanState_e;

  // control -> datapath
  typedef struct packed {
    logic start;
    logic capture;
    logic wordDone;
  } dpStrobe_t;

  // datapath -> control: ring position
  typedef struct packed {
    logic periodEnd;
    logic ringEnd;
    logic burstEnd;
  } dpFlag_t;

  // datapath -> control: decoded setup and command events
  typedef struct packed {
    logic goReq;
    logic haltReq;
    logic dirOk;
    logic toPeriph;
    logic lenOk;
    logic ringMode;
    logic flowEn;
    logic pauseReq;
  } chanCfg_t;

  typedef struct packed {
    logic xferEn;
    logic paused;
  } chanStat_t;

endpackage

// File: rtl/ring_dma_dp.sv
module ring_dma_dp
  import ring_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 8,
  parameter int PCNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  dpStrobe_t         stb,
  input  chanStat_t         stat,
  output chanCfg_t          cfg,
  output dpFlag_t           flag,
  output logic [DATA_W-1:0] curAddr,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] holdData,
  output logic [PCNT_W-1:0] periodCnt,
  output logic              intPend
);

  localparam int WORD_W  = DATA_W - 2;
  localparam int RING_W  = 3;
  localparam int BURST_W = 4;
  localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

  logic [DATA_W-1:0] ctrlReg, cfgReg, srcReg, trgReg, lenReg;
  logic              cmdBit;
  logic [WORD_W-1:0] wordIdx, periodWords;
  logic [RING_W-1:0] ringIdx, ringLast;
  logic [BURST_W-1:0] burstIdx, burstLast;
  logic [DATA_W-1:0] baseAddr;
  logic              locked;

  function automatic logic hit(input logic [REG_AW-1:0] a, input logic [7:0] ofs);
    return a == REG_AW'(ofs);
  endfunction

  assign locked = stat.xferEn;

  // decoded setup
  assign cfg.toPeriph = ctrlReg[15:12] == DIR_TO_PERIPH;
  assign cfg.dirOk    = cfg.toPeriph || (ctrlReg[15:12] == DIR_TO_MEM);
  assign cfg.ringMode = ctrlReg[9:8] == MODE_RING;
  assign cfg.flowEn   = ctrlReg[1];
  assign cfg.pauseReq = ctrlReg[0];
  assign cfg.goReq    = regWr && hit(regAddr, OFS_CMD) && regWdata[0];
  assign cfg.haltReq  = regWr && hit(regAddr, OFS_CMD) && !regWdata[0];

  assign periodWords = lenReg[DATA_W-1:2];
  assign cfg.lenOk   = |periodWords;
  assign ringLast    = cfg.toPeriph ? cfgReg[30:28] : cfgReg[26:24];
  assign burstLast   = cfgReg[23:20];
  assign baseAddr    = cfg.toPeriph ? srcReg : trgReg;

  assign flag.periodEnd = wordIdx == (periodWords - WORD_W'(1));
  assign flag.ringEnd   = flag.periodEnd && (ringIdx == ringLast);
  assign flag.burstEnd  = burstIdx == burstLast;

  assign holdData = holdReg;
  logic [DATA_W-1:0] holdReg;

  // software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBit  <= 1'b0;
      ctrlReg <= '0;
      cfgReg  <= '0;
      srcReg  <= '0;
      trgReg  <= '0;
      lenReg  <= '0;
    end else if (regWr) begin
      if (hit(regAddr, OFS_CMD)) cmdBit <= regWdata[0];
      if (hit(regAddr, OFS_CTRL)) begin
        if (locked) ctrlReg[0] <= regWdata[0];
        else        ctrlReg    <= regWdata;
      end
      if (!locked) begin
        if (hit(regAddr, OFS_CFG)) cfgReg <= regWdata;
        if (hit(regAddr, OFS_SRC)) srcReg <= regWdata;
        if (hit(regAddr, OFS_TRG)) trgReg <= regWdata;
        if (hit(regAddr, OFS_LEN)) lenReg <= regWdata & LEN_MASK;
      end
    end
  end

  // interrupt flag: a period end wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intPend <= 1'b0;
    else if (stb.wordDone && flag.periodEnd) intPend <= 1'b1;
    else if (regWr && hit(regAddr, OFS_ICLR) && regWdata[0]) intPend <= 1'b0;
  end

  // ring position, address and period count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx   <= '0;
      ringIdx   <= '0;
      burstIdx  <= '0;
      periodCnt <= '0;
      curAddr   <= '0;
    end else if (stb.start) begin
      wordIdx   <= '0;
      ringIdx   <= '0;
      burstIdx  <= '0;
      periodCnt <= '0;
      curAddr   <= baseAddr;
    end else if (stb.wordDone) begin
      burstIdx <= (flag.burstEnd || flag.periodEnd) ? '0 : burstIdx + BURST_W'(1);
      if (flag.periodEnd) begin
        wordIdx   <= '0;
        periodCnt <= periodCnt + PCNT_W'(1);
        if (flag.ringEnd) begin
          ringIdx <= '0;
          curAddr <= baseAddr;
        end else begin
          ringIdx <= ringIdx + RING_W'(1);
          curAddr <= curAddr + STEP;
        end
      end else begin
        wordIdx <= wordIdx + WORD_W'(1);
        curAddr <= curAddr + STEP;
      end
    end
  end

  // word holding register, shared by both directions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdReg <= '0;
    else if (stb.capture) holdReg <= cfg.toPeriph ? memRdata : rxData;
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (hit(regAddr, OFS_CMD))   regRdata = DATA_W'(cmdBit);
    if (hit(regAddr, OFS_STAT))  regRdata = DATA_W'({stat.paused, stat.xferEn});
    if (hit(regAddr, OFS_ISTAT)) regRdata = DATA_W'(intPend);
    if (hit(regAddr, OFS_CTRL))  regRdata = ctrlReg;
    if (hit(regAddr, OFS_CFG))   regRdata = cfgReg;
    if (hit(regAddr, OFS_SRC))   regRdata = srcReg;
    if (hit(regAddr, OFS_TRG))   regRdata = trgReg;
    if (hit(regAddr, OFS_LEN))   regRdata = lenReg;
    if (hit(regAddr, OFS_XSTAT)) regRdata = DATA_W'(periodCnt);
  end

endmodule

// File: rtl/ring_dma_ctrl.sv
module ring_dma_ctrl
  import ring_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  chanCfg_t  cfg,
  input  dpFlag_t   flag,
  input  logic      memAck,
  input  logic      txReady,
  input  logic      rxValid,
  output dpStrobe_t stb,
  output chanStat_t stat,
  output logic      memReq,
  output logic      memWe,
  output logic      txValid,
  output logic      rxReady
);

  chanState_e state, nextState, firstState;
  logic haltPend, haltNow, boundary;

  assign firstState = cfg.toPeriph ? S_RD : S_PULL;
  assign haltNow    = haltPend || cfg.haltReq;
  assign boundary   = flag.burstEnd || flag.periodEnd;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (cfg.goReq && cfg.dirOk && cfg.lenOk) begin
        stb.start = 1'b1;
        nextState = firstState;
      end
      S_RD: if (memAck) begin
        stb.capture = 1'b1;
        nextState   = S_PUSH;
      end
      S_PUSH: if (txReady || !cfg.flowEn) stb.wordDone = 1'b1;
      S_PULL: if (rxValid || !cfg.flowEn) begin
        stb.capture = 1'b1;
        nextState   = S_WR;
      end
      S_WR:   if (memAck) stb.wordDone = 1'b1;
      S_HOLD: begin
        if (haltNow)            nextState = S_IDLE;
        else if (!cfg.pauseReq) nextState = firstState;
      end
      default: nextState = S_IDLE;
    endcase
    if (stb.wordDone) begin
      if (flag.ringEnd && !cfg.ringMode)  nextState = S_IDLE;
      else if (boundary && haltNow)       nextState = S_IDLE;
      else if (boundary && cfg.pauseReq)  nextState = S_HOLD;
      else                                nextState = firstState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      haltPend <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == S_IDLE) haltPend <= 1'b0;
      else if (cfg.haltReq)    haltPend <= 1'b1;
    end
  end

  assign stat.xferEn = state != S_IDLE;
  assign stat.paused = state == S_HOLD;
  assign memReq      = (state == S_RD) || (state == S_WR);
  assign memWe       = state == S_WR;
  assign txValid     = state == S_PUSH;
  assign rxReady     = state == S_PULL;

endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import ring_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 8,
  parameter int PCNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              irq
);

  dpStrobe_t stb;
  dpFlag_t   flag;
  chanCfg_t  cfg;
  chanStat_t stat;
  logic [DATA_W-1:0] holdData;
  logic [PCNT_W-1:0] periodCnt;
  logic              intPend;

  ring_dma_dp #(.DATA_W(DATA_W), .REG_AW(REG_AW), .PCNT_W(PCNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .stb(stb), .stat(stat), .cfg(cfg), .flag(flag),
    .curAddr(memAddr), .memRdata(memRdata), .rxData(rxData),
    .holdData(holdData), .periodCnt(periodCnt), .intPend(intPend)
  );

  ring_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfg(cfg), .flag(flag),
    .memAck(memAck), .txReady(txReady), .rxValid(rxValid),
    .stb(stb), .stat(stat),
    .memReq(memReq), .memWe(memWe), .txValid(txValid), .rxReady(rxReady)
  );

  assign txData   = holdData;
  assign memWdata = holdData;
  assign irq      = intPend;

endmodule

// File: rtl/ring_dma_chk.sv
module ring_dma_chk #(
  parameter int DATA_W = 32,
  parameter int PCNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              xferEn,
  input logic              paused,
  input logic              memReq,
  input logic              txValid,
  input logic              txReady,
  input logic              rxReady,
  input logic              flowEn,
  input logic              startStb,
  input logic              irq,
  input logic [DATA_W-1:0] txData,
  input logic [PCNT_W-1:0] periodCnt
);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !xferEn |-> !memReq && !txValid && !rxReady);

  p_pause_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    paused |-> !memReq && !txValid && !rxReady);

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady && flowEn |=> txValid && $stable(txData));

  p_count_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (periodCnt != $past(periodCnt)) && !$past(startStb)
      |-> periodCnt == $past(periodCnt) + 1'b1);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(xferEn));

endmodule

bind ring_dma_chan ring_dma_chk #(.DATA_W(DATA_W), .PCNT_W(PCNT_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .xferEn(stat.xferEn), .paused(stat.paused),
  .memReq(memReq), .txValid(txValid), .txReady(txReady), .rxReady(rxReady),
  .flowEn(cfg.flowEn), .startStb(stb.start), .irq(irq),
  .txData(txData), .periodCnt(periodCnt)
);

// File: tb/ring_dma_chan_tb.sv
`timescale 1ns/1ps
module ring_dma_chan_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memAck = 1'b1;
  logic        txValid;
  logic [31:0] txData;
  logic        txReady = 1'b1;
  logic        rxValid = 1'b0;
  logic [31:0] rxData = '0;
  logic        rxReady;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:63];
  logic [31:0] txLog [0:255];
  int  txCount = 0;
  bit  benchFc = 1'b1;
  bit  sawReq = 1'b0;
  bit  rxOn = 1'b0;
  bit  rxPend = 1'b0;
  int  rxSeq = 0;
  int  cyc = 0;

  always #2.5 clk = ~clk;

  ring_dma_chan u_dut (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .irq(irq)
  );

  // memory model
  assign memRdata = mem[memAddr[7:2]];
  always @(posedge clk) if (memReq && memWe && memAck) mem[memAddr[7:2]] <= memWdata;

  // stream monitor and receive source
  always @(negedge clk) begin
    cyc++;
    if (memReq) sawReq = 1'b1;
    if (txValid && (txReady || !benchFc)) begin
      if (txCount < 256) txLog[txCount] = txData;
      txCount++;
    end
    if (rxPend) rxSeq++;
    rxValid = rxOn && ((cyc % 3) != 0);
    rxData  = 32'hB000_0000 + rxSeq;
    rxPend  = rxValid && rxReady;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle(input int limit);
    logic [31:0] s;
    for (int i = 0; i < limit; i++) begin
      rd(8'h0C, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic clearIrq();
    logic [31:0] v;
    wr(8'h1C, 32'h1);
    rd(8'h10, v);
    chk("R10 istat after clear", v, 32'h0);
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic fillMem();
    for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + i;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h0C, v); chk("R1 status", v, 0);
    rd(8'h10, v); chk("R1 istat", v, 0);
    rd(8'h24, v); chk("R1 ctrl", v, 0);
    rd(8'h28, v); chk("R1 cfg", v, 0);
    rd(8'h54, v); chk("R1 count", v, 0);
    chk("R1 outputs", {28'b0, irq, memReq, txValid, rxReady}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h34, 32'h0000_0040); rd(8'h34, v); chk("R2 src", v, 32'h40);
    wr(8'h3C, 32'h0000_0080); rd(8'h3C, v); chk("R2 trg", v, 32'h80);
    wr(8'h28, 32'h1234_5671); rd(8'h28, v); chk("R2 cfg", v, 32'h1234_5671);
    wr(8'h24, 32'h0000_4206); rd(8'h24, v); chk("R2 ctrl", v, 32'h4206);
    rd(8'h1C, v); chk("R2 iclr reads zero", v, 0);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, v); chk("R13 len mask", v, 32'h3FFF_FFFC);
  endtask

  task automatic t_badStart();
    logic [31:0] v;
    sawReq = 1'b0;
    wr(8'h24, 32'h0000_3202);
    wr(8'h44, 32'h8);
    wr(8'h00, 32'h1);
    repeat (3) @(negedge clk);
    rd(8'h0C, v); chk("R3 bad direction not started", v, 0);
    wr(8'h24, 32'h0000_4202);
    wr(8'h44, 32'h3);
    rd(8'h44, v); chk("R13 sub-word length masked", v, 0);
    wr(8'h00, 32'h1);
    repeat (3) @(negedge clk);
    rd(8'h0C, v); chk("R3 zero length not started", v, 0);
    chk("R3 no memory request", {31'b0, sawReq}, 0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_ring();
    logic [31:0] v, n;
    int bad = 0;
    fillMem();
    wr(8'h34, 32'h0);
    wr(8'h44, 32'h8);
    wr(8'h28, 32'h2010_0001);
    wr(8'h24, 32'h0000_4202);
    benchFc = 1'b1; txReady = 1'b1; txCount = 0;
    wr(8'h00, 32'h1);
    rd(8'h0C, v); chk("R3 started", v, 32'h1);
    for (int i = 0; i < 500; i++) begin
      rd(8'h54, v);
      if (v >= 4) break;
    end
    wr(8'h00, 32'h0);
    waitIdle(100);
    rd(8'h0C, v); chk("R8 stopped", v, 0);
    rd(8'h54, n);
    chk("R11 count reached", {31'b0, n >= 4}, 32'h1);
    chk("R8 stop on period edge", txCount, n * 2);
    for (int k = 0; k < txCount && k < 256; k++)
      if (txLog[k] !== 32'hA000_0000 + (k % 6)) bad++;
    chk("R4 ring order and wrap", bad, 0);
    chk("R10 irq raised", {31'b0, irq}, 32'h1);
    clearIrq();
  endtask

  task automatic t_rxOnce();
    logic [31:0] v;
    int bad = 0;
    for (int i = 32; i < 40; i++) mem[i] = 32'hDEAD_0000;
    wr(8'h3C, 32'h80);
    wr(8'h44, 32'hC);
    wr(8'h28, 32'h01F0_0000);
    wr(8'h24, 32'h0000_2002);
    rxSeq = 0; rxOn = 1'b1;
    wr(8'h00, 32'h1);
    waitIdle(300);
    rxOn = 1'b0;
    for (int i = 0; i < 6; i++) if (mem[32 + i] !== 32'hB000_0000 + i) bad++;
    chk("R5 R7 received words in order", bad, 0);
    chk("R6 nothing past ring", mem[38], 32'hDEAD_0000);
    rd(8'h0C, v); chk("R6 self stop", v, 0);
    rd(8'h54, v); chk("R11 count restarted", v, 2);
    rd(8'h10, v); chk("R10 istat set", v, 1);
    clearIrq();
  endtask

  task automatic t_noFlow();
    logic [31:0] v;
    int bad = 0;
    fillMem();
    wr(8'h34, 32'h0);
    wr(8'h44, 32'h10);
    wr(8'h28, 32'h0);
    wr(8'h24, 32'h0000_4000);
    benchFc = 1'b0; txReady = 1'b0; txCount = 0;
    wr(8'h00, 32'h1);
    waitIdle(50);
    rd(8'h0C, v); chk("R7 finished without ready", v, 0);
    chk("R7 word count", txCount, 4);
    for (int i = 0; i < 4; i++) if (txLog[i] !== 32'hA000_0000 + i) bad++;
    chk("R7 words in order", bad, 0);
    rd(8'h54, v); chk("R11 one period", v, 1);
    benchFc = 1'b1; txReady = 1'b1;
    clearIrq();
  endtask

  task automatic t_pause();
    logic [31:0] v;
    int c1, bad = 0;
    fillMem();
    wr(8'h34, 32'h0);
    wr(8'h44, 32'h20);
    wr(8'h28, 32'h0030_0000);
    wr(8'h24, 32'h0000_4202);
    txCount = 0;
    wr(8'h00, 32'h1);
    repeat (5) @(negedge clk);
    wr(8'h24, 32'h0000_2001);
    for (int i = 0; i < 100; i++) begin
      rd(8'h0C, v);
      if (v[1]) break;
    end
    c1 = txCount;
    chk("R9 paused status", v, 32'h3);
    chk("R9 halted on burst edge", {31'b0, (c1 % 4 == 0) && (c1 > 0)}, 32'h1);
    rd(8'h24, v); chk("R12 only pause bit taken", v, 32'h4203);
    wr(8'h34, 32'h40);  rd(8'h34, v); chk("R12 src locked", v, 0);
    wr(8'h44, 32'h100); rd(8'h44, v); chk("R12 len locked", v, 32'h20);
    wr(8'h28, 32'h7);   rd(8'h28, v); chk("R12 cfg locked", v, 32'h0030_0000);
    repeat (20) @(negedge clk);
    #1 chk("R9 no traffic while paused", txCount, c1);
    wr(8'h24, 32'h0000_4202);
    repeat (20) @(negedge clk);
    #1 chk("R9 resumed", {31'b0, txCount > c1}, 32'h1);
    for (int k = 0; k < txCount && k < 256; k++)
      if (txLog[k] !== 32'hA000_0000 + (k % 8)) bad++;
    chk("R9 sequence continues", bad, 0);
    wr(8'h00, 32'h0);
    waitIdle(100);
    rd(8'h0C, v); chk("R8 stopped after resume", v, 0);
    clearIrq();
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    fillMem();
    wr(8'h34, 32'h0);
    wr(8'h44, 32'h4);
    wr(8'h28, 32'h0);
    wr(8'h24, 32'h0000_4200);
    benchFc = 1'b0;
    wr(8'h00, 32'h1);
    for (int i = 0; i < 140000; i++) begin
      rd(8'h54, v);
      if (v == 32'hFFFF) break;
    end
    chk("R11 count reaches top", v, 32'hFFFF);
    for (int i = 0; i < 10; i++) begin
      rd(8'h54, v);
      if (v != 32'hFFFF) break;
    end
    chk("R11 count wraps", v, 32'h0);
    wr(8'h00, 32'h0);
    waitIdle(20);
    rd(8'h0C, v); chk("R8 stopped", v, 0);
    benchFc = 1'b1;
  endtask

  initial begin
    fillMem();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_badStart();
    t_ring();
    t_rxOnce();
    t_noFlow();
    t_pause();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule